// File: doc/BRIEF.md
# Four-Word Dual-Port Register File

This block stores four words of four bits. A write port and a read port work at the same time and independently of each other. The write port takes a word address, a data word and an active-low write strobe. While the strobe is low, the addressed word follows the data input level by level. While the strobe is high, the write address and the data are ignored.

The read port takes its own word address and an active-low read enable. While enabled, it drives the addressed word in true form onto a three-state output. It also raises a separate drive-enable flag. While disabled, the output floats. Several copies can share one bus, up to a 512-word bank, as long as only one read enable is low at a time.

Storage can be built in two ways, chosen by a parameter: level-sensitive latches, or clocked flops paired with a write-through bypass. In both forms, a read of the word being written shows the input data in the same cycle. No reset exists, so contents are undefined until each word is written.

Top module: `quad_regfile`

## Requirements
- R1: Write address value k (binary, 0 to 3) stores the data word into word k; a later read with read address k returns exactly that 4-bit value.
- R2: Writing word k leaves the other three words unchanged.
- R3: While the write strobe is high (1), changes on the write address and data inputs alter no stored word.
- R4: While the write strobe is low and the read address equals the write address, the enabled output equals the data input in the same cycle and follows each change of it; the last value present when the strobe rises stays stored.
- R5: While one word is being written, reading a different word returns that word's stored value, whatever the data input does.
- R6: With read enable low (0), the drive flag is 1 and the bus carries the addressed word uninverted. With read enable high (1), the drive flag is 0 and the bus is high-impedance.
- R7: Two copies whose outputs are wired to one bus, with one read enable low, present that copy's word on the bus with no unknown bits; only the enabled copy raises its drive flag.
- R8: Latch storage and flop-with-bypass storage give identical port values for writes whose strobe spans a rising clock edge and whose data is steady between that edge and the strobe's rise.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flop storage variant and for the property checks |
| weN | input | 1 | Active-low write strobe |
| waddr | input | 2 | Word address for writes |
| dIn | input | 4 | Write data |
| reN | input | 1 | Active-low read enable |
| raddr | input | 2 | Word address for reads |
| busQ | output | 4 | Three-state read data, floats while reN is high |
| busOe | output | 1 | High while busQ is driven |

## Verification
Every read result is combinational: it is due in the same cycle as the read address, enable or bypassed data that produces it. The one exception is a stored word in the flop variant, which is due after the first rising edge inside the write strobe. The bench therefore changes inputs on falling edges. It holds each write strobe low across exactly one rising edge, and samples all outputs one nanosecond after the following rising edge. By then both storage forms have settled to the same value.

// File: rtl/qrf_pkg.sv
package qrf_pkg;

  typedef struct packed {
    logic writeOn;  // write strobe asserted
    logic hit;      // read and write address match while writing
    logic driveOn;  // read port drives the bus
  } qrf_strobe_t;

endpackage

// File: rtl/qrf_ctrl.sv
module qrf_ctrl
  import qrf_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              weN,
  input  logic              reN,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ADDR_W-1:0] raddr,
  output qrf_strobe_t       strobe,
  output logic [WORDS-1:0]  wordEn
);

  always_comb begin
    strobe.writeOn = ~weN;
    strobe.hit     = ~weN && (waddr == raddr);
    strobe.driveOn = ~reN;
  end

  for (genvar i = 0; i < WORDS; i++) begin : gen_dec
    assign wordEn[i] = ~weN && (waddr == ADDR_W'(i));
  end

  // R2: at most one word opens for writing
  a_r2_single_word: assert property (@(posedge clk) $onehot0(wordEn));

  // R1: an active write always opens the addressed word
  a_r1_addr_select: assert property (@(posedge clk)
    (weN === 1'b0 && !$isunknown(waddr)) |-> wordEn[waddr]);

endmodule

// File: rtl/qrf_dp.sv
module qrf_dp
  import qrf_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int ADDR_W      = 2,
  parameter bit LATCH_STORE = 1'b1,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  qrf_strobe_t       strobe,
  input  logic [WORDS-1:0]  wordEn,
  input  logic [DATA_W-1:0] dIn,
  input  logic [ADDR_W-1:0] raddr,
  output wire  [DATA_W-1:0] busQ
);

  logic [WORDS-1:0][DATA_W-1:0] memQ;
  logic [DATA_W-1:0]            rdWord;

  for (genvar i = 0; i < WORDS; i++) begin : gen_word
    if (LATCH_STORE) begin : gen_latch
      logic [DATA_W-1:0] cellQ;
      always_latch begin
        if (wordEn[i]) cellQ <= dIn;
      end
      assign memQ[i] = cellQ;
    end else begin : gen_flop
      logic [DATA_W-1:0] cellQ;
      always_ff @(posedge clk) begin
        if (wordEn[i]) cellQ <= dIn;
      end
      assign memQ[i] = cellQ;
    end
  end

  if (LATCH_STORE) begin : gen_rd_latch
    // the open latch is already transparent to dIn
    assign rdWord = memQ[raddr];
  end else begin : gen_rd_flop
    assign rdWord = strobe.hit ? dIn : memQ[raddr];
  end

  assign busQ = strobe.driveOn ? rdWord : {DATA_W{1'bz}};

  // R4: a matching read shows the write data with no delay
  a_r4_write_through: assert property (@(posedge clk)
    (strobe.hit && strobe.driveOn && !$isunknown(dIn)) |-> (busQ == dIn));

  // R3: storage is frozen across a cycle with no write
  a_r3_hold: assert property (@(posedge clk)
    (!strobe.writeOn && $past(!strobe.writeOn) && !$isunknown($past(memQ)))
      |-> $stable(memQ));

endmodule

// File: rtl/quad_regfile.sv
module quad_regfile
  import qrf_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int ADDR_W      = 2,
  parameter bit LATCH_STORE = 1'b1,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              weN,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] dIn,
  input  logic              reN,
  input  logic [ADDR_W-1:0] raddr,
  output wire  [DATA_W-1:0] busQ,
  output logic              busOe
);

  qrf_strobe_t      strobe;
  logic [WORDS-1:0] wordEn;

  qrf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .weN    (weN),
    .reN    (reN),
    .waddr  (waddr),
    .raddr  (raddr),
    .strobe (strobe),
    .wordEn (wordEn)
  );

  qrf_dp #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .LATCH_STORE (LATCH_STORE)
  ) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .wordEn (wordEn),
    .dIn    (dIn),
    .raddr  (raddr),
    .busQ   (busQ)
  );

  assign busOe = strobe.driveOn;

endmodule

// File: tb/quad_regfile_tb.sv
`timescale 1ns/1ps
module quad_regfile_tb;

  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       weN = 1'b1, reN = 1'b1;
  logic       weNA = 1'b1, weNB = 1'b1, reNA = 1'b1, reNB = 1'b1;
  logic [1:0] waddr = '0, raddr = '0;
  logic [3:0] dIn = '0;

  wire  [3:0] busDut, busAlt, sharedBus;
  logic       oeDut, oeAlt, oeA, oeB;

  quad_regfile #(.LATCH_STORE(1'b1)) u_dut (
    .clk(clk), .weN(weN), .waddr(waddr), .dIn(dIn),
    .reN(reN), .raddr(raddr), .busQ(busDut), .busOe(oeDut));

  quad_regfile #(.LATCH_STORE(1'b0)) u_alt (
    .clk(clk), .weN(weN), .waddr(waddr), .dIn(dIn),
    .reN(reN), .raddr(raddr), .busQ(busAlt), .busOe(oeAlt));

  quad_regfile #(.LATCH_STORE(1'b1)) u_bankA (
    .clk(clk), .weN(weNA), .waddr(waddr), .dIn(dIn),
    .reN(reNA), .raddr(raddr), .busQ(sharedBus), .busOe(oeA));

  quad_regfile #(.LATCH_STORE(1'b0)) u_bankB (
    .clk(clk), .weN(weNB), .waddr(waddr), .dIn(dIn),
    .reN(reNB), .raddr(raddr), .busQ(sharedBus), .busOe(oeB));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] model [4];
  logic [3:0] modelA [4];
  logic [3:0] modelB [4];

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  task automatic writeWord(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    waddr = a; dIn = d; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    model[a] = d;
  endtask

  task automatic readBoth(input string req, input logic [1:0] a);
    @(negedge clk);
    raddr = a; reN = 1'b0;
    sample();
    check(req, busDut, model[a]);
    check({req, "/R8"}, busAlt, busDut);
  endtask

  task automatic readAll(input string req);
    for (int k = 0; k < 4; k++) readBoth(req, 2'(k));
  endtask

  initial begin
    // R6: disabled port floats and flags no drive
    sample();
    check("R6 idle oe dut", {3'b0, oeDut}, 4'h0);
    check("R6 idle oe alt", {3'b0, oeAlt}, 4'h0);
    check("R6 idle oe bank", {2'b0, oeA, oeB}, 4'h0);

    // R1 / R8: fill every word, then read each back
    for (int k = 0; k < 4; k++) writeWord(2'(k), 4'((k * 5 + 3) & 15));
    readAll("R1 fill");
    check("R6 enabled oe", {2'b0, oeDut, oeAlt}, 4'h3);

    // R1 / R2: every value into every word, neighbours checked each time
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 16; v++) begin
        writeWord(2'(k), 4'(v));
        readAll("R2 sweep");
      end
    end

    // R3: strobe high, address and data wander
    for (int k = 0; k < 4; k++) writeWord(2'(k), 4'(9 - 2 * k));
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      waddr = 2'(s); dIn = 4'(s * 7);
    end
    readAll("R3 hold");

    // R4: write-through on matching address
    @(negedge clk);
    waddr = 2'd2; raddr = 2'd2; reN = 1'b0; weN = 1'b0;
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      dIn = 4'(15 - v);
      sample();
      check("R4 through dut", busDut, 4'(15 - v));
      check("R4 through alt", busAlt, 4'(15 - v));
    end
    @(negedge clk);
    weN = 1'b1;
    model[2] = 4'h0;
    readAll("R4 last kept");

    // R5: read another word while one is being written
    @(negedge clk);
    waddr = 2'd1; raddr = 2'd3; weN = 1'b0;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      dIn = 4'(v * 3);
      sample();
      check("R5 other dut", busDut, model[3]);
      check("R5 other alt", busAlt, model[3]);
    end
    @(negedge clk);
    weN = 1'b1;
    model[1] = 4'(7 * 3);
    readAll("R5 after");

    // R6: toggle the read enable
    @(negedge clk);
    reN = 1'b1;
    sample();
    check("R6 off oe", {2'b0, oeDut, oeAlt}, 4'h0);
    @(negedge clk);
    reN = 1'b0; raddr = 2'd0;
    sample();
    check("R6 on data", busDut, model[0]);

    // R7: two copies on one bus
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      waddr = 2'(k); dIn = 4'(k + 8); weNA = 1'b0;
      @(negedge clk);
      weNA = 1'b1; modelA[k] = 4'(k + 8);
      @(negedge clk);
      dIn = 4'(6 - k); weNB = 1'b0;
      @(negedge clk);
      weNB = 1'b1; modelB[k] = 4'(6 - k);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      raddr = 2'(k); reNA = 1'b0; reNB = 1'b1;
      sample();
      check("R7 bus A", sharedBus, modelA[k]);
      check("R7 oe A", {2'b0, oeA, oeB}, 4'h2);
      check("R7 known A", {3'b0, $isunknown(sharedBus)}, 4'h0);
      @(negedge clk);
      reNA = 1'b1; reNB = 1'b0;
      sample();
      check("R7 bus B", sharedBus, modelB[k]);
      check("R7 oe B", {2'b0, oeA, oeB}, 4'h1);
    end
    @(negedge clk);
    reNB = 1'b1;
    sample();
    check("R7 both off", {2'b0, oeA, oeB}, 4'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule